// File: doc/BRIEF.md
# Normally-Ready Bus Wait-State Generator

This block serves one peripheral on a synchronous processor bus where every access finishes at its default time unless the addressed target objects. It watches the address-latch strobe together with the peripheral's chip select. When both are high at a rising clock edge, the block decides that the current bus cycle belongs to its peripheral.

It then pulls the processor's synchronous ready input low for a programmable number of clock cycles, taken from the wait-count input at that edge. After those cycles it releases ready high again so the processor can close the cycle. Each cycle of not-ready costs the processor one more clock of read or write strobe. A count of zero leaves ready high throughout, so the strobe ends at its normal time.

After the release, the block keeps ready high and ignores further strobes until the read or write strobe of the current access goes away. Only then does it accept a new access. Ready comes straight from a register, so it changes only at rising clock edges and meets the processor's setup window.

Top module: `bus_wait_gen`

## Requirements
- R1: While reset is applied, and at any time no access is being stretched, `rdy_o` is 1 (ready).
- R2: An access is detected only at a rising edge where `ale_i` and `cs_i` are both 1. An `ale_i` pulse with `cs_i` at 0 never drives `rdy_o` to 0.
- R3: When an access is detected with `wait_i` = N (N from 1 to 15), `rdy_o` is 0 from that edge on, for exactly N consecutive clock cycles.
- R4: After the N not-ready cycles, `rdy_o` returns to 1 and stays 1 while `rd_i` or `wr_i` (1 = strobe asserted) remains 1.
- R5: When an access is detected with `wait_i` = 0, `rdy_o` stays 1 for the whole access.
- R6: An `ale_i`/`cs_i` pulse that arrives while ready is held low, or while the strobe of the current access is still 1 after release, neither restarts nor adds to the wait.
- R7: Once both strobes are 0 after an access, the block is idle. The next detected access is stretched by the `wait_i` value sampled at its own detection edge.
- R8: `wait_i` is sampled only at the detection edge. Changing it during the wait does not change the number of not-ready cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ale_i | input | 1 | Address-latch enable from the processor |
| cs_i | input | 1 | Chip select for this peripheral, 1 = selected |
| rd_i | input | 1 | Read strobe, 1 = asserted |
| wr_i | input | 1 | Write strobe, 1 = asserted |
| wait_i | input | CNT_W (4) | Number of wait states for this peripheral |
| rdy_o | output | 1 | Synchronous ready to the processor, 1 = ready |

## Verification
Ready is registered. If the stimulus for an access is applied before rising edge k, `rdy_o` first shows 0 in the sample taken after edge k. It is back at 1 after edge k+N. The bench drives and samples on falling edges only. Each access is therefore read as a window of half-cycle-offset samples, in which the number of 0 samples must equal N and no 0 may follow the first 1. The idle check is taken one falling edge after the strobe is dropped, which is the first edge at which the block can have returned to idle.

// File: rtl/bus_wait_gen_pkg.sv
package bus_wait_gen_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_DONE = 2'd2
  } wg_state_e;
endpackage

// File: rtl/wg_rst_sync.sv
module wg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/wg_down_cnt.sv
module wg_down_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         dec_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load_i | dec_i;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = ld_val_i;
    else if (dec_i) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == W'(1));

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i) |=> (cnt_q == W'($past(cnt_q) - W'(1)))); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> (cnt_q != '0)); // R3
endmodule

// File: rtl/wg_ctrl.sv
module wg_ctrl
  import bus_wait_gen_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ale_i,
  input  logic         cs_i,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic [W-1:0] wait_i,
  input  logic         cnt_last_i,
  output logic         cnt_load_o,
  output logic         cnt_dec_o,
  output logic         rdy_o
);
  wg_state_e st_q, st_d;
  logic      rdy_q, rdy_d, rdy_en;
  logic      detect, strobe, zero_wait;

  assign detect    = ale_i & cs_i;
  assign strobe    = rd_i | wr_i;
  assign zero_wait = (wait_i == '0);

  always_comb begin
    st_d       = st_q;
    cnt_load_o = 1'b0;
    cnt_dec_o  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (detect) begin
          if (zero_wait) begin
            st_d = ST_DONE;
          end else begin
            st_d       = ST_HOLD;
            cnt_load_o = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (cnt_last_i) st_d = ST_DONE;
        else            cnt_dec_o = 1'b1;
      end
      ST_DONE: begin
        if (!strobe) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign rdy_d  = (st_d != ST_HOLD);
  assign rdy_en = (rdy_d != rdy_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdy_q <= 1'b1;
    else if (rdy_en) rdy_q <= rdy_d;
  end

  assign rdy_o = rdy_q;

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> rdy_q); // R1
  AST_NOCS_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && ale_i && !cs_i) |=> rdy_q); // R2
  AST_STALL_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && detect && !zero_wait) |=> !rdy_q); // R3
  AST_RELEASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE && strobe) |=> (st_q == ST_DONE && rdy_q)); // R4
  AST_ZERO_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && detect && zero_wait) |=> rdy_q); // R5
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD && detect && !cnt_last_i) |=> (st_q == ST_HOLD && !cnt_load_o)); // R6
endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen #(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ale_i,
  input  logic             cs_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wait_i,
  output logic             rdy_o
);
  logic rst_sn;
  logic cnt_load, cnt_dec, cnt_last;

  wg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  wg_down_cnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sn),
    .load_i   (cnt_load),
    .ld_val_i (wait_i),
    .dec_i    (cnt_dec),
    .last_o   (cnt_last)
  );

  wg_ctrl #(.W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sn),
    .ale_i      (ale_i),
    .cs_i       (cs_i),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .wait_i     (wait_i),
    .cnt_last_i (cnt_last),
    .cnt_load_o (cnt_load),
    .cnt_dec_o  (cnt_dec),
    .rdy_o      (rdy_o)
  );
endmodule

// File: tb/sim_bus_wait_gen.sv
`timescale 1ns/1ps
module sim_bus_wait_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ale = 1'b0, cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [3:0] wcnt = 4'd0;
  logic       rdy;
  int         total = 0;
  int         bad = 0;

  always #2.5 clk = ~clk;

  bus_wait_gen u0 (
    .clk(clk), .rst_n(rst_n), .ale_i(ale), .cs_i(cs),
    .rd_i(rd), .wr_i(wr), .wait_i(wcnt), .rdy_o(rdy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(rdy == 1'b1, "R1 ready during reset", int'(rdy), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rdy == 1'b1, "R1 ready after reset", int'(rdy), 1);
  endtask

  // mode 0: plain; 1: extra ale+cs pulse at index inj; 2: wait_i changed to 12 at index 0
  task automatic t_access(input int n, input bit use_wr, input bit sel,
                          input int mode, input int inj, input string tag);
    int  lows = 0;
    bit  seen_hi = 0;
    bit  relow = 0;
    int  exp_lows = sel ? n : 0;
    @(negedge clk);
    ale = 1'b1; cs = sel; wcnt = 4'(n);
    for (int i = 0; i < 22; i++) begin
      @(negedge clk);
      if (i == 0) begin
        chk(rdy == (exp_lows == 0), {tag, " first cycle"}, int'(rdy), int'(exp_lows == 0));
        ale = 1'b0; cs = 1'b0;
        if (use_wr) wr = 1'b1; else rd = 1'b1;
        if (mode == 2) wcnt = 4'd12;
      end
      if (mode == 1 && i == inj) begin ale = 1'b1; cs = 1'b1; wcnt = 4'd9; end
      if (mode == 1 && i == inj + 1) begin ale = 1'b0; cs = 1'b0; end
      if (!rdy) begin
        lows++;
        if (seen_hi) relow = 1'b1;
      end else seen_hi = 1'b1;
    end
    chk(lows == exp_lows, {tag, " not-ready cycles"}, lows, exp_lows);
    chk(!relow, {tag, " R4 ready stays high after release"}, int'(relow), 0);
    chk(rdy == 1'b1, {tag, " R4 ready before strobe end"}, int'(rdy), 1);
    rd = 1'b0; wr = 1'b0;
    @(negedge clk);
    chk(rdy == 1'b1, {tag, " R1 idle after strobe end"}, int'(rdy), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_access(3, 1'b0, 1'b1, 0, 0, "R3 read n=3");
    t_access(1, 1'b1, 1'b1, 0, 0, "R3 write n=1");
    t_access(15, 1'b0, 1'b1, 0, 0, "R3 boundary n=15");
    t_access(0, 1'b1, 1'b1, 0, 0, "R5 zero wait");
    t_access(5, 1'b0, 1'b0, 0, 0, "R2 no chip select");
    t_access(6, 1'b0, 1'b1, 1, 2, "R6 pulse during hold");
    t_access(2, 1'b1, 1'b1, 1, 6, "R6 pulse after release");
    t_access(4, 1'b0, 1'b1, 2, 0, "R8 wait change mid-access");
    t_access(7, 1'b1, 1'b1, 0, 0, "R7 new access count");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule